// File: doc/BRIEF.md
# MSI Snooping Line Coherence Controller

This block keeps coherence for a small direct-mapped, write-back cache that sits on a shared snooping bus and uses invalidation. Each line has a tag and one of three states. Invalid means the line holds nothing. Shared means it holds a clean, read-only copy. Modified means it holds the only copy, which may be written. The local processor issues reads and writes that hit or miss by tag compare. Misses and upgrades go out as bus requests over a valid/ready handshake, and the processor is stalled until the request completes.

The block also watches the read-miss and write-miss transactions that other caches put on the bus. When a snooped transaction names a block this cache holds Modified, the block supplies the line with a write-back pulse and tells memory to drop its own reply. It then demotes the line to Shared after a snooped read, or to Invalid after a snooped write. A processor miss that evicts a Modified line of a different tag first writes the victim back and then issues the miss. The data array and bus arbitration live outside this block.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `bus_req_valid`, `cpu_ack`, `snoop_wb` and `mem_abort` are low.
- R2: A read to a line that is Invalid issues one bus request with command 1 (read miss) at the block address, which is the request address with its low `OFFS_W` bits cleared. When the request is granted, the line becomes Shared.
- R3: A write to an Invalid line issues one command 2 (write miss) at the block address, and the line becomes Modified.
- R4: A write that hits a Shared line issues a command 2 at the block address, and the line becomes Modified.
- R5: A read hit in Shared or Modified, and a write hit in Modified, raise `cpu_ack` in the cycle after the request is accepted. They issue no bus request.
- R6: A read whose index holds a Modified line of another tag first issues command 3 (write-back) at the victim's block address, then a command 1 for the new block. The line ends Shared under the new tag.
- R7: A write whose index holds a Modified line of another tag issues command 3 for the victim, then command 2 for the new block. The line ends Modified under the new tag.
- R8: A snooped write miss (`snoop_is_write`=1) to a block held Shared makes it Invalid, with no write-back and no abort.
- R9: A snooped write miss to a block held Modified raises `snoop_wb` and `mem_abort` for exactly the cycle after the snoop, and the line becomes Invalid.
- R10: A snooped read miss (`snoop_is_write`=0) to a block held Modified raises `snoop_wb` and `mem_abort` for one cycle, and the line becomes Shared.
- R11: A snooped read miss to a Shared block, or a snoop whose tag differs from the stored one, changes nothing and raises no abort.
- R12: While a miss request waits for `bus_req_ready`, its command and address hold steady, `cpu_stall` stays high and `cpu_ack` stays low. After a granted write-back, the miss request follows in the next cycle.
- R13: When a snoop and a processor request name the same index in the same cycle, the snoop is applied first. The processor request is then judged against the post-snoop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present; held until `cpu_ack` |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Processor byte address |
| cpu_stall | output | 1 | Request present and not yet acknowledged |
| cpu_ack | output | 1 | One-cycle completion pulse |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_cmd | output | 2 | 1 read miss, 2 write miss, 3 write-back |
| bus_req_addr | output | ADDR_W | Block address of the request |
| bus_req_ready | input | 1 | Bus grants the pending request |
| snoop_valid | input | 1 | Snooped transaction present |
| snoop_is_write | input | 1 | 1 = snooped write miss, 0 = snooped read miss |
| snoop_addr | input | ADDR_W | Snooped address |
| snoop_wb | output | 1 | This cache supplies the snooped Modified line |
| mem_abort | output | 1 | Memory must not answer the snooped transaction |

## Verification
A line left in the wrong state shows up only on the next access to that index. A Shared line wrongly kept after an invalidating snoop lets a read complete with no bus request, one cycle after acceptance. A line wrongly left Modified after a snooped read lets a write complete silently instead of issuing a write miss. A wrong victim tag shows as a write-back to the wrong block address in the first cycle of the eviction. Abort and write-back errors show one cycle after the snoop, so every check is paired with a follow-up access that reveals the stored state.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_MOD = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BUS_NONE   = 2'd0,
        BUS_RDMISS = 2'd1,
        BUS_WRMISS = 2'd2,
        BUS_WBACK  = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        PF_IDLE  = 2'd0,
        PF_WBACK = 2'd1,
        PF_MISS  = 2'd2,
        PF_DONE  = 2'd3
    } pfsm_e;

    // State after a snoop that matched a valid line.
    function automatic line_st_e snoop_next(line_st_e cur, logic is_wr);
        if (is_wr)
            return LN_INV;
        else if (cur == LN_MOD)
            return LN_SHR;
        else
            return cur;
    endfunction

    // A matched snoop needs this cache to supply the data only when it owns it.
    function automatic logic snoop_supplies(line_st_e cur);
        return cur == LN_MOD;
    endfunction

endpackage

// File: rtl/msi_tag_store.sv
module msi_tag_store
    import msi_pkg::*;
#(
    parameter int LINES = 4,
    parameter int TAG_W = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    // processor-side lookup
    input  logic [IDX_W-1:0] pl_idx,
    output logic [TAG_W-1:0] pl_tag,
    output line_st_e         pl_st,
    // snoop-side lookup
    input  logic [IDX_W-1:0] sl_idx,
    output logic [TAG_W-1:0] sl_tag,
    output line_st_e         sl_st,
    // snoop-side state update (applied first)
    input  logic             sn_we,
    input  line_st_e         sn_st,
    // processor-side fill / clear (applied last, wins on same index)
    input  logic             pu_we,
    input  logic [IDX_W-1:0] pu_idx,
    input  logic [TAG_W-1:0] pu_tag,
    input  line_st_e         pu_st
);

    logic [TAG_W-1:0] tag_q [LINES];
    line_st_e         st_q  [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= '0;
                st_q[i]  <= LN_INV;
            end
        end else begin
            if (sn_we)
                st_q[sl_idx] <= sn_st;
            if (pu_we) begin
                st_q[pu_idx]  <= pu_st;
                tag_q[pu_idx] <= pu_tag;
            end
        end
    end

    assign pl_tag = tag_q[pl_idx];
    assign pl_st  = st_q[pl_idx];
    assign sl_tag = tag_q[sl_idx];
    assign sl_st  = st_q[sl_idx];

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snoop_valid,
    input  logic             snoop_is_write,
    input  logic [TAG_W-1:0] snoop_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  line_st_e         line_st,
    output logic             st_we,
    output line_st_e         st_new,
    output logic             supply_q
);

    logic match;
    logic supply_d;

    assign match    = snoop_valid && (line_st != LN_INV) && (line_tag == snoop_tag);
    assign st_we    = match;
    assign st_new   = snoop_next(line_st, snoop_is_write);
    assign supply_d = match && snoop_supplies(line_st);

    always_ff @(posedge clk) begin
        if (rst)
            supply_q <= 1'b0;
        else
            supply_q <= supply_d;
    end

endmodule

// File: rtl/msi_proc_fsm.sv
module msi_proc_fsm
    import msi_pkg::*;
#(
    parameter int OFFS_W = 2,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 8,
    localparam int ADDR_W = TAG_W + IDX_W + OFFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [TAG_W-1:0]  cpu_tag,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic              snoop_same_idx,
    output logic [IDX_W-1:0]  look_idx,
    input  logic [TAG_W-1:0]  line_tag,
    input  line_st_e          line_st,
    input  logic              bus_req_ready,
    output logic              bus_req_valid,
    output bus_cmd_e          bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic              pu_we,
    output logic [IDX_W-1:0]  pu_idx,
    output logic [TAG_W-1:0]  pu_tag,
    output line_st_e          pu_st,
    output logic              cpu_ack,
    output logic              cpu_stall
);

    localparam logic [OFFS_W-1:0] ZERO_OFFS = '0;

    pfsm_e            st_q, st_d;
    logic [TAG_W-1:0] req_tag_q;
    logic [IDX_W-1:0] req_idx_q;
    logic             req_wr_q;
    logic             accept;
    logic             tag_hit;

    assign look_idx = (st_q == PF_IDLE) ? cpu_idx : req_idx_q;
    assign pu_idx   = req_idx_q;
    assign accept   = (st_q == PF_IDLE) && cpu_req_valid && !snoop_same_idx;
    assign tag_hit  = (line_st != LN_INV) && (line_tag == cpu_tag);
    assign cpu_ack  = (st_q == PF_DONE);
    assign cpu_stall = cpu_req_valid && !cpu_ack;

    always_comb begin
        st_d          = st_q;
        bus_req_valid = 1'b0;
        bus_req_cmd   = BUS_NONE;
        bus_req_addr  = '0;
        pu_we         = 1'b0;
        pu_tag        = req_tag_q;
        pu_st         = LN_INV;
        unique case (st_q)
            PF_IDLE: begin
                if (accept) begin
                    if (tag_hit && (!cpu_req_write || line_st == LN_MOD))
                        st_d = PF_DONE;
                    else if (!tag_hit && line_st == LN_MOD)
                        st_d = PF_WBACK;
                    else
                        st_d = PF_MISS;
                end
            end
            PF_WBACK: begin
                if (line_st != LN_MOD) begin
                    // victim already surrendered to a snoop
                    st_d = PF_MISS;
                end else begin
                    bus_req_valid = 1'b1;
                    bus_req_cmd   = BUS_WBACK;
                    bus_req_addr  = {line_tag, req_idx_q, ZERO_OFFS};
                    if (bus_req_ready) begin
                        pu_we  = 1'b1;
                        pu_tag = line_tag;
                        pu_st  = LN_INV;
                        st_d   = PF_MISS;
                    end
                end
            end
            PF_MISS: begin
                bus_req_valid = 1'b1;
                bus_req_cmd   = req_wr_q ? BUS_WRMISS : BUS_RDMISS;
                bus_req_addr  = {req_tag_q, req_idx_q, ZERO_OFFS};
                if (bus_req_ready) begin
                    pu_we  = 1'b1;
                    pu_tag = req_tag_q;
                    pu_st  = req_wr_q ? LN_MOD : LN_SHR;
                    st_d   = PF_DONE;
                end
            end
            PF_DONE: st_d = PF_IDLE;
            default: st_d = PF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= PF_IDLE;
            req_tag_q <= '0;
            req_idx_q <= '0;
            req_wr_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                req_tag_q <= cpu_tag;
                req_idx_q <= cpu_idx;
                req_wr_q  <= cpu_req_write;
            end
        end
    end

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OFFS_W = 2,
    parameter int LINES  = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - OFFS_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_stall,
    output logic              cpu_ack,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_req_ready,
    input  logic              snoop_valid,
    input  logic              snoop_is_write,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              snoop_wb,
    output logic              mem_abort
);

    logic [TAG_W-1:0] cpu_tag, snp_tag, pl_tag, sl_tag, pu_tag;
    logic [IDX_W-1:0] cpu_idx, snp_idx, look_idx, pu_idx;
    line_st_e         pl_st, sl_st, sn_st, pu_st;
    logic             sn_we, pu_we, supply_q;
    bus_cmd_e         cmd;
    logic             unused_offs;

    assign cpu_tag = cpu_req_addr[ADDR_W-1 -: TAG_W];
    assign cpu_idx = cpu_req_addr[OFFS_W +: IDX_W];
    assign snp_tag = snoop_addr[ADDR_W-1 -: TAG_W];
    assign snp_idx = snoop_addr[OFFS_W +: IDX_W];
    assign unused_offs = ^{cpu_req_addr[OFFS_W-1:0], snoop_addr[OFFS_W-1:0]};

    msi_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .pl_idx (look_idx),
        .pl_tag (pl_tag),
        .pl_st  (pl_st),
        .sl_idx (snp_idx),
        .sl_tag (sl_tag),
        .sl_st  (sl_st),
        .sn_we  (sn_we),
        .sn_st  (sn_st),
        .pu_we  (pu_we),
        .pu_idx (pu_idx),
        .pu_tag (pu_tag),
        .pu_st  (pu_st)
    );

    msi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
        .clk            (clk),
        .rst            (rst),
        .snoop_valid    (snoop_valid),
        .snoop_is_write (snoop_is_write),
        .snoop_tag      (snp_tag),
        .line_tag       (sl_tag),
        .line_st        (sl_st),
        .st_we          (sn_we),
        .st_new         (sn_st),
        .supply_q       (supply_q)
    );

    msi_proc_fsm #(.OFFS_W(OFFS_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_proc (
        .clk            (clk),
        .rst            (rst),
        .cpu_req_valid  (cpu_req_valid),
        .cpu_req_write  (cpu_req_write),
        .cpu_tag        (cpu_tag),
        .cpu_idx        (cpu_idx),
        .snoop_same_idx (snoop_valid && (snp_idx == cpu_idx)),
        .look_idx       (look_idx),
        .line_tag       (pl_tag),
        .line_st        (pl_st),
        .bus_req_ready  (bus_req_ready),
        .bus_req_valid  (bus_req_valid),
        .bus_req_cmd    (cmd),
        .bus_req_addr   (bus_req_addr),
        .pu_we          (pu_we),
        .pu_idx         (pu_idx),
        .pu_tag         (pu_tag),
        .pu_st          (pu_st),
        .cpu_ack        (cpu_ack),
        .cpu_stall      (cpu_stall)
    );

    assign bus_req_cmd = cmd;
    assign snoop_wb    = supply_q;
    assign mem_abort   = supply_q;

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_ack,
    input logic              bus_req_valid,
    input logic [1:0]        bus_req_cmd,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic              bus_req_ready,
    input logic              snoop_valid,
    input logic              mem_abort
);

    p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && !bus_req_ready && bus_req_cmd != 2'd3)
        |=> (bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_addr)));

    p_wb_then_miss_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && bus_req_ready && bus_req_cmd == 2'd3)
        |=> (bus_req_valid && bus_req_cmd != 2'd3 && bus_req_cmd != 2'd0));

    p_ack_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |=> !cpu_ack);

    p_ack_quiet_bus_r5: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |-> !bus_req_valid);

    p_abort_follows_snoop_r9: assert property (@(posedge clk) disable iff (rst)
        mem_abort |-> $past(snoop_valid));

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cpu_ack       (cpu_ack),
    .bus_req_valid (bus_req_valid),
    .bus_req_cmd   (bus_req_cmd),
    .bus_req_addr  (bus_req_addr),
    .bus_req_ready (bus_req_ready),
    .snoop_valid   (snoop_valid),
    .mem_abort     (mem_abort)
);

// File: tb/tb_msi_snoop_ctrl.sv
`timescale 1ns/1ps
module tb_msi_snoop_ctrl;

    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_req_valid = 1'b0;
    logic              cpu_req_write = 1'b0;
    logic [ADDR_W-1:0] cpu_req_addr = '0;
    logic              cpu_stall, cpu_ack;
    logic              bus_req_valid;
    logic [1:0]        bus_req_cmd;
    logic [ADDR_W-1:0] bus_req_addr;
    logic              bus_req_ready = 1'b0;
    logic              snoop_valid = 1'b0;
    logic              snoop_is_write = 1'b0;
    logic [ADDR_W-1:0] snoop_addr = '0;
    logic              snoop_wb, mem_abort;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    msi_snoop_ctrl #(.ADDR_W(ADDR_W), .OFFS_W(2), .LINES(4)) dut (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_stall(cpu_stall), .cpu_ack(cpu_ack),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
        .bus_req_addr(bus_req_addr), .bus_req_ready(bus_req_ready),
        .snoop_valid(snoop_valid), .snoop_is_write(snoop_is_write),
        .snoop_addr(snoop_addr), .snoop_wb(snoop_wb), .mem_abort(mem_abort)
    );

    task automatic chk(input bit ok, input int r, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL R%0d %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    // One processor access, with an optional snoop launched in the same cycle.
    task automatic run_op(input logic w, input logic [11:0] a, input int n,
                          input logic [1:0] c0, input logic [11:0] a0,
                          input logic [1:0] c1, input logic [11:0] a1,
                          input int r, input int lat,
                          input bit sv, input bit swr, input logic [11:0] sa,
                          input bit sab);
        int nreq = 0;
        int wcnt = 0;
        int cycles = 0;
        bit done = 0;
        logic [1:0]  lc = '0;
        logic [11:0] la = '0;
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = w;
        cpu_req_addr  = a;
        if (sv) begin
            snoop_valid = 1'b1;
            snoop_is_write = swr;
            snoop_addr = sa;
        end
        for (int k = 0; k < 40 && !done; k++) begin
            @(negedge clk);
            cycles++;
            bus_req_ready = 1'b0;
            if (k == 0 && sv) begin
                snoop_valid = 1'b0;
                chk(mem_abort == sab, r, "abort with concurrent snoop", mem_abort, sab);
            end
            if (cpu_ack) begin
                done = 1;
                cpu_req_valid = 1'b0;
            end else if (bus_req_valid) begin
                if (wcnt == 0) begin
                    lc = bus_req_cmd;
                    la = bus_req_addr;
                    if (nreq >= n)
                        chk(1'b0, r, "unexpected bus request cmd", bus_req_cmd, 0);
                    else begin
                        chk(bus_req_cmd == ((nreq == 0) ? c0 : c1), r, "bus cmd",
                            bus_req_cmd, (nreq == 0) ? c0 : c1);
                        chk(bus_req_addr == ((nreq == 0) ? a0 : a1), r, "bus addr",
                            bus_req_addr, (nreq == 0) ? a0 : a1);
                    end
                    nreq++;
                end else begin
                    // R12: held request, stalled processor
                    chk(bus_req_cmd == lc && bus_req_addr == la && cpu_stall,
                        12, "request held while waiting", {bus_req_cmd, bus_req_addr}, {lc, la});
                end
                if (wcnt == lat) begin
                    bus_req_ready = 1'b1;
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end
        end
        cpu_req_valid = 1'b0;
        chk(done, r, "ack seen", done, 1);
        chk(nreq == n, r, "bus request count", nreq, n);
        if (n == 0 && !sv)
            chk(cycles == 1, r, "hit latency", cycles, 1);
    endtask

    task automatic snoop_only(input bit swr, input logic [11:0] sa, input bit sab, input int r);
        @(negedge clk);
        snoop_valid = 1'b1;
        snoop_is_write = swr;
        snoop_addr = sa;
        @(negedge clk);
        snoop_valid = 1'b0;
        chk(mem_abort == sab && snoop_wb == sab, r, "abort/wb after snoop",
            {snoop_wb, mem_abort}, {sab, sab});
        @(negedge clk);
        chk(!mem_abort && !snoop_wb, r, "abort pulse ends", {snoop_wb, mem_abort}, 0);
    endtask

    typedef struct packed {
        logic        w;
        logic [11:0] a;
        logic [1:0]  n;
        logic [1:0]  c0;
        logic [11:0] a0;
        logic [1:0]  c1;
        logic [11:0] a1;
        logic [3:0]  r;
    } vec_t;

    // cmd: 1 read miss, 2 write miss, 3 write-back; index = addr[3:2], tag = addr[11:4]
    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 12'h013, 2'd1, 2'd1, 12'h010, 2'd0, 12'h000, 4'd2},  // R2 read from Invalid
        '{1'b0, 12'h010, 2'd0, 2'd0, 12'h000, 2'd0, 12'h000, 4'd5},  // R5 read hit Shared
        '{1'b1, 12'h010, 2'd1, 2'd2, 12'h010, 2'd0, 12'h000, 4'd4},  // R4 upgrade
        '{1'b1, 12'h012, 2'd0, 2'd0, 12'h000, 2'd0, 12'h000, 4'd5},  // R5 write hit Modified
        '{1'b0, 12'h011, 2'd0, 2'd0, 12'h000, 2'd0, 12'h000, 4'd5},  // R5 read hit Modified
        '{1'b0, 12'h110, 2'd2, 2'd3, 12'h010, 2'd1, 12'h110, 4'd6},  // R6 conflict read
        '{1'b1, 12'h024, 2'd1, 2'd2, 12'h024, 2'd0, 12'h000, 4'd3},  // R3 write from Invalid
        '{1'b1, 12'h027, 2'd0, 2'd0, 12'h000, 2'd0, 12'h000, 4'd5},  // R5 write hit
        '{1'b1, 12'h224, 2'd2, 2'd3, 12'h024, 2'd2, 12'h224, 4'd7},  // R7 conflict write
        '{1'b1, 12'h225, 2'd0, 2'd0, 12'h000, 2'd0, 12'h000, 4'd7},  // R7 new tag is Modified
        '{1'b0, 12'h110, 2'd0, 2'd0, 12'h000, 2'd0, 12'h000, 4'd6},  // R6 new tag is Shared
        '{1'b0, 12'h0A8, 2'd1, 2'd1, 12'h0A8, 2'd0, 12'h000, 4'd2}   // R2 other index
    };

    bit finished = 0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!bus_req_valid && !cpu_ack && !mem_abort && !snoop_wb && !cpu_stall, 1,
            "idle outputs after reset",
            {bus_req_valid, cpu_ack, mem_abort, snoop_wb, cpu_stall}, 0);

        for (int i = 0; i < NV; i++) begin
            run_op(TBL[i].w, TBL[i].a, int'(TBL[i].n), TBL[i].c0, TBL[i].a0,
                   TBL[i].c1, TBL[i].a1, int'(TBL[i].r), i % 3, 1'b0, 1'b0, 12'h0, 1'b0);
        end

        // R8: invalidating snoop on a Shared line, then the read misses again
        snoop_only(1'b1, 12'h110, 1'b0, 8);
        run_op(1'b0, 12'h110, 1, 2'd1, 12'h110, 2'd0, 12'h0, 8, 1, 1'b0, 1'b0, 12'h0, 1'b0);

        // R11: read snoop on Shared and a foreign-tag snoop leave the line alone
        snoop_only(1'b0, 12'h110, 1'b0, 11);
        snoop_only(1'b1, 12'h310, 1'b0, 11);
        run_op(1'b0, 12'h112, 0, 2'd0, 12'h0, 2'd0, 12'h0, 11, 0, 1'b0, 1'b0, 12'h0, 1'b0);

        // R9: write snoop on a Modified line
        snoop_only(1'b1, 12'h224, 1'b1, 9);
        run_op(1'b0, 12'h224, 1, 2'd1, 12'h224, 2'd0, 12'h0, 9, 0, 1'b0, 1'b0, 12'h0, 1'b0);

        // R10: read snoop on a Modified line demotes it to Shared
        run_op(1'b1, 12'h0A8, 1, 2'd2, 12'h0A8, 2'd0, 12'h0, 4, 1, 1'b0, 1'b0, 12'h0, 1'b0);
        snoop_only(1'b0, 12'h0A8, 1'b1, 10);
        run_op(1'b0, 12'h0A8, 0, 2'd0, 12'h0, 2'd0, 12'h0, 10, 0, 1'b0, 1'b0, 12'h0, 1'b0);
        run_op(1'b1, 12'h0A8, 1, 2'd2, 12'h0A8, 2'd0, 12'h0, 10, 0, 1'b0, 1'b0, 12'h0, 1'b0);

        // R13: snoop write and processor write to the same Modified line together
        run_op(1'b1, 12'h0A8, 1, 2'd2, 12'h0A8, 2'd0, 12'h0, 13, 1, 1'b1, 1'b1, 12'h0A8, 1'b1);

        // R12: long grant latency on an eviction
        run_op(1'b0, 12'h3A8, 2, 2'd3, 12'h0A8, 2'd1, 12'h3A8, 12, 5, 1'b0, 1'b0, 12'h0, 1'b0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule